// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns stereo PCM sample words into a bit clock, a frame clock and a serial data line. It always drives both clocks itself. A single serializer covers five framings. The classic two-channel format with a one-bit delay, left-justified and right-justified each give every channel its own half of the frame. Two short-frame DSP variants mark the frame with a one-bit pulse and pack both slots back to back. A two-bit format code and a two-bit data delay choose the framing.

Samples come from a show-ahead transmit FIFO through a pop strobe. Each FIFO word carries a 16-bit sample in its upper half. The block fetches the two words of the next frame just after each frame boundary. A single-cycle `bit_tick` input sets the serial rate: two ticks make one bit-clock period. Both clock outputs have their own polarity inversion. Each slot can be muted, and each slot can be remapped to either fetched channel. The data pin has an enable output that can also float the line outside the sample windows.

Top module: `audio_tx_serializer`

## Requirements
- R1: During reset and while `en` is low, `bclk` equals `bclk_inv`, `fclk` equals `fclk_inv`, `sdata` and `sdata_oe` are 0, and neither `fifo_pop` nor `underrun` is asserted.
- R2: Once running, every `bit_tick` toggles the internal bit clock, which starts low. `bclk` is that clock XOR `bclk_inv`. Frame position and data advance only on a tick that takes the internal clock from high to low. Without a tick, `bclk` holds.
- R3: Each channel half lasts `half_len_m1`+1 bit clocks, and a frame is two halves.
- R4: Format codes 1 and 3 (left-justified) drive the raw frame clock low in the first half and high in the second. Slot 0 goes in the first half and slot 1 in the second. Each slot's sample goes out MSB first, beginning `data_ofs` bit clocks after its half starts. A delay of 1 gives the classic delayed format. All other bits are 0.
- R5: Format code 2 (right-justified) uses the same frame clock as R4. It places each sample's LSB on the last bit clock of its half, with zeros before the sample. `data_ofs` has no effect in this format.
- R6: Format code 0 (short frame) drives the raw frame clock high only during bit clock 0 of the frame. Slot 0 takes the 16 bit clocks that start `data_ofs` bit clocks into the frame, and slot 1 takes the next 16. A delay of 1 gives DSP-A and a delay of 0 gives DSP-B.
- R7: `fclk` is the raw frame clock XOR `fclk_inv`.
- R8: A slot whose bit in `slot_en` is 0 sends zeros. Bit 0 controls slot 0.
- R9: Slot k sends the first word fetched for the frame when `slot_src[k]` is 0, and the second word when it is 1. The value 2'b10 is the identity map.
- R10: On the first enabled cycle, and at every frame boundary, the block fetches two FIFO words in the next two cycles. It uses bits 31:16 of each word and ignores bits 15:0. The samples go out in the following frame, so the first frame after enable carries zeros.
- R11: If the FIFO is empty during a fetch cycle, the block does not pop. It raises `underrun` for that cycle, and that channel sends zero.
- R12: `sdata_oe` is high only while running with `sd_en` set. When `hiz_idle` is also set, `sdata_oe` also drops outside the sample bits of enabled slots. `sdata` is 0 whenever `sdata_oe` is low.
- R13: Dropping `en` returns the block to the idle state of R1 on the next cycle and discards buffered samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| bit_tick | input | 1 | Half-bit-period strobe |
| fmt_mode | input | 2 | Format code: 0 short frame, 1/3 left-justified, 2 right-justified |
| data_ofs | input | 2 | Data delay in bit clocks |
| half_len_m1 | input | 5 | Bit clocks per channel half minus one |
| bclk_inv | input | 1 | Invert bit clock |
| fclk_inv | input | 1 | Invert frame clock |
| sd_en | input | 1 | Data output enable |
| hiz_idle | input | 1 | Release the data line outside sample windows |
| slot_en | input | 2 | Per-slot enable |
| slot_src | input | 2 | Per-slot channel source |
| fifo_data | input | 32 | FIFO head word |
| fifo_empty | input | 1 | FIFO empty |
| fifo_pop | output | 1 | Pop strobe |
| underrun | output | 1 | Fetch attempted on empty FIFO |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Serial data drive enable |

## Verification
The bench targets the points where the formats differ:
- The one-bit delay that separates the classic format from left-justified, and DSP-A from DSP-B. A design that ignored the delay would send every sample one bit early.
- Right-justified alignment with a half length shorter than 32. A design that counted from the wrong end would put the LSB off the last bit clock and corrupt the start of the sample.
- Underrun in the middle of a frame's fetch, swapped and muted slots, and a disable mid-frame. A design that kept stale samples or popped an empty FIFO would leak old data into the next frame or lose FIFO words.

// File: rtl/audio_tx_serializer.sv
`timescale 1ns/1ps
module audio_tx_serializer #(
  parameter int WORD_W   = 32,
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_tick,
  input  logic [1:0]        fmt_mode,
  input  logic [1:0]        data_ofs,
  input  logic [CNT_W-1:0]  half_len_m1,
  input  logic              bclk_inv,
  input  logic              fclk_inv,
  input  logic              sd_en,
  input  logic              hiz_idle,
  input  logic [1:0]        slot_en,
  input  logic [1:0]        slot_src,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  output logic              underrun,
  output logic              bclk,
  output logic              fclk,
  output logic              sdata,
  output logic              sdata_oe
);
  localparam int IDXW = $clog2(SAMPLE_W);
  localparam logic [1:0] FMT_SHORT = 2'd0;
  localparam logic [1:0] FMT_RIGHT = 2'd2;

  logic                run, phase, side;
  logic [CNT_W-1:0]    cnt;
  logic [1:0]          fetch;
  logic [SAMPLE_W-1:0] cur0, cur1, pend0, pend1, word, head;
  logic [IDXW-1:0]     bsel;
  logic                slot, in_win, fraw, fetching;
  int                  half, pos, q, b;

  logic unused_low;
  assign unused_low = ^fifo_data[WORD_W-SAMPLE_W-1:0];

  assign head     = fifo_empty ? '0 : fifo_data[WORD_W-1 -: SAMPLE_W];
  assign fetching = run && (fetch != 2'd0);
  assign fifo_pop = fetching && !fifo_empty;
  assign underrun = fetching && fifo_empty;

  always_comb begin
    half = int'(half_len_m1) + 1;
    pos  = side ? half + int'(cnt) : int'(cnt);
    slot = side;
    b    = -1;
    q    = 0;
    fraw = side;
    case (fmt_mode)
      FMT_SHORT: begin
        fraw = (pos == 0);
        q    = pos - int'(data_ofs);
        slot = 1'b0;
        if (q >= 0 && q < 2*SAMPLE_W) begin
          slot = (q >= SAMPLE_W);
          b    = q % SAMPLE_W;
        end
      end
      FMT_RIGHT: b = int'(cnt) + SAMPLE_W - half;
      default:   b = int'(cnt) - int'(data_ofs);
    endcase
    in_win = run && b >= 0 && b < SAMPLE_W && slot_en[slot];
    word   = slot_src[slot] ? cur1 : cur0;
    bsel   = IDXW'(SAMPLE_W - 1 - b);
  end

  assign bclk     = (run & phase) ^ bclk_inv;
  assign fclk     = (run & fraw) ^ fclk_inv;
  assign sdata_oe = run && sd_en && !(hiz_idle && !in_win);
  assign sdata    = sdata_oe && in_win && word[bsel];

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      run   <= 1'b0;
      phase <= 1'b0;
      side  <= 1'b0;
      cnt   <= '0;
      fetch <= 2'd0;
      cur0  <= '0;
      cur1  <= '0;
      pend0 <= '0;
      pend1 <= '0;
    end else if (!run) begin
      run   <= 1'b1;
      fetch <= 2'd2;
    end else begin
      if (fetch != 2'd0) begin
        if (fetch == 2'd2) pend0 <= head;
        else               pend1 <= head;
        fetch <= fetch - 2'd1;
      end
      if (bit_tick) begin
        phase <= ~phase;
        if (phase) begin
          if (cnt == half_len_m1) begin
            cnt  <= '0;
            side <= ~side;
            if (side) begin
              cur0  <= pend0;
              cur1  <= pend1;
              fetch <= 2'd2;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_tx_serializer_chk.sv
`timescale 1ns/1ps
module audio_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic bit_tick,
  input logic bclk_inv,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic underrun,
  input logic bclk,
  input logic sdata,
  input logic sdata_oe
);
  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  assert_underrun_no_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (fifo_empty && !fifo_pop));

  assert_quiet_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);

  assert_idle_after_disable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sdata_oe && !fifo_pop && !underrun));

  assert_bclk_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_tick) |=> ((bclk ^ bclk_inv) == $past(bclk ^ bclk_inv)));
endmodule

bind audio_tx_serializer audio_tx_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bit_tick(bit_tick), .bclk_inv(bclk_inv),
  .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .underrun(underrun),
  .bclk(bclk), .sdata(sdata), .sdata_oe(sdata_oe)
);

// File: tb/test_audio_tx_serializer.sv
`timescale 1ns/1ps
module test_audio_tx_serializer;
  logic clk = 0, rst_n = 0, en = 0, bit_tick = 0;
  logic [1:0] fmt_mode = 2'd1, data_ofs = 2'd0;
  logic [4:0] half_len_m1 = 5'd31;
  logic bclk_inv = 0, fclk_inv = 0, sd_en = 1, hiz_idle = 0;
  logic [1:0] slot_en = 2'b11, slot_src = 2'b10;
  logic [31:0] fifo_data = '0;
  logic fifo_empty = 1;
  logic fifo_pop, underrun, bclk, fclk, sdata, sdata_oe;

  always #5 clk = ~clk;

  audio_tx_serializer i_audio_tx_serializer (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_tick(bit_tick), .fmt_mode(fmt_mode),
    .data_ofs(data_ofs), .half_len_m1(half_len_m1), .bclk_inv(bclk_inv),
    .fclk_inv(fclk_inv), .sd_en(sd_en), .hiz_idle(hiz_idle), .slot_en(slot_en),
    .slot_src(slot_src), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .underrun(underrun), .bclk(bclk), .fclk(fclk),
    .sdata(sdata), .sdata_oe(sdata_oe));

  int checks = 0, failures = 0;
  string tag = "R1";
  int gap = 2, tick_ctr = 0;
  bit feed = 1;
  logic [31:0] q[$];
  logic [15:0] seed = 16'h1234;
  int m_run = 0, m_phase = 0, m_pos = 0, m_fetch = 0;
  logic [15:0] m_cur[2], m_pend[2];

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic expect_out(output logic eb, output logic ef, output logic es, output logic eo);
    int h, side, c, qq, slot, b;
    logic win, bitv;
    h = int'(half_len_m1) + 1;
    side = (m_pos >= h) ? 1 : 0;
    c = m_pos - side * h;
    slot = 0; b = -1;
    if (m_run == 0) begin
      eb = bclk_inv; ef = fclk_inv; es = 0; eo = 0;
      return;
    end
    case (fmt_mode)
      2'd0: begin
        ef = (m_pos == 0);
        qq = m_pos - int'(data_ofs);
        if (qq >= 0 && qq < 32) begin slot = qq / 16; b = qq % 16; end
      end
      2'd2: begin ef = (side == 1); slot = side; b = c + 16 - h; end
      default: begin ef = (side == 1); slot = side; b = c - int'(data_ofs); end
    endcase
    ef = ef ^ fclk_inv;
    win = (b >= 0) && (b < 16) && slot_en[slot];
    bitv = win && m_cur[slot_src[slot]][15 - b];
    eo = sd_en && !(hiz_idle && !win);
    es = eo && bitv;
    eb = (m_phase != 0) ^ bclk_inv;
  endtask

  initial begin
    logic eb, ef, es, eo, ep, eu;
    m_cur[0] = 0; m_cur[1] = 0; m_pend[0] = 0; m_pend[1] = 0;
    forever begin
      @(negedge clk);
      expect_out(eb, ef, es, eo);
      chk(tag, "bclk", bclk, eb);
      chk(tag, "fclk", fclk, ef);
      chk(tag, "sdata", sdata, es);
      chk(tag, "sdata_oe", sdata_oe, eo);
      fifo_empty = (q.size() == 0);
      fifo_data = fifo_empty ? 32'h0 : q[0];
      bit_tick = (tick_ctr == 0);
      tick_ctr = (tick_ctr >= gap - 1) ? 0 : tick_ctr + 1;
      #1;
      ep = (m_run != 0) && (m_fetch > 0) && !fifo_empty;
      eu = (m_run != 0) && (m_fetch > 0) && fifo_empty;
      chk("R10", "fifo_pop", fifo_pop, ep);
      chk("R11", "underrun", underrun, eu);
      if (!rst_n || !en) begin
        m_run = 0; m_phase = 0; m_pos = 0; m_fetch = 0;
        m_cur[0] = 0; m_cur[1] = 0; m_pend[0] = 0; m_pend[1] = 0;
      end else if (m_run == 0) begin
        m_run = 1; m_fetch = 2;
      end else begin
        if (m_fetch > 0) begin
          if (fifo_empty) m_pend[2 - m_fetch] = 16'h0;
          else begin
            m_pend[2 - m_fetch] = q[0][31:16];
            void'(q.pop_front());
          end
          m_fetch--;
        end
        if (bit_tick) begin
          if (m_phase == 0) m_phase = 1;
          else begin
            m_phase = 0;
            m_pos++;
            if (m_pos == 2 * (int'(half_len_m1) + 1)) begin
              m_pos = 0;
              m_cur[0] = m_pend[0]; m_cur[1] = m_pend[1];
              m_fetch = 2;
            end
          end
        end
      end
      if (feed) while (q.size() < 4) begin
        seed = seed * 16'd25173 + 16'd13849;
        q.push_back({seed, 16'hA5A5});
      end
    end
  end

  task automatic run_phase(string t, int mode, int ofs, int hm1, bit bi, bit fi, bit sde,
                           bit hz, logic [1:0] se, logic [1:0] src, int g, bit fd, int frames);
    @(posedge clk); #1 en = 0;
    repeat (3) @(posedge clk);
    #1;
    tag = t; fmt_mode = 2'(mode); data_ofs = 2'(ofs); half_len_m1 = 5'(hm1);
    bclk_inv = bi; fclk_inv = fi; sd_en = sde; hiz_idle = hz;
    slot_en = se; slot_src = src; gap = g; feed = fd;
    en = 1;
    repeat (frames * 4 * (hm1 + 1) * g + 6) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset sdata_oe", sdata_oe, 1'b0);
    chk("R1", "reset fifo_pop", fifo_pop, 1'b0);
    chk("R1", "reset bclk", bclk, bclk_inv);
    @(posedge clk); #1 rst_n = 1;
    repeat (4) @(posedge clk);
    run_phase("R4", 1, 0, 31, 0, 0, 1, 0, 2'b11, 2'b10, 2, 1, 3);
    run_phase("R4", 1, 1, 31, 0, 0, 1, 0, 2'b11, 2'b10, 1, 1, 3);
    run_phase("R4", 3, 2, 23, 0, 0, 1, 0, 2'b11, 2'b10, 2, 1, 2);
    run_phase("R5", 2, 0, 31, 0, 0, 1, 0, 2'b11, 2'b10, 2, 1, 3);
    run_phase("R5", 2, 2, 19, 0, 0, 1, 0, 2'b11, 2'b10, 2, 1, 3);
    run_phase("R6", 0, 0, 31, 0, 0, 1, 0, 2'b11, 2'b10, 2, 1, 3);
    run_phase("R6", 0, 1, 15, 0, 0, 1, 0, 2'b11, 2'b10, 2, 1, 3);
    run_phase("R7", 1, 1, 31, 0, 1, 1, 0, 2'b11, 2'b10, 2, 1, 2);
    run_phase("R2", 1, 1, 31, 1, 0, 1, 0, 2'b11, 2'b10, 3, 1, 2);
    run_phase("R3", 1, 3, 19, 0, 0, 1, 0, 2'b11, 2'b10, 2, 1, 3);
    run_phase("R8", 1, 0, 31, 0, 0, 1, 0, 2'b01, 2'b10, 2, 1, 2);
    run_phase("R8", 0, 1, 31, 0, 0, 1, 0, 2'b10, 2'b10, 2, 1, 2);
    run_phase("R9", 1, 1, 31, 0, 0, 1, 0, 2'b11, 2'b01, 2, 1, 3);
    run_phase("R9", 2, 0, 31, 0, 0, 1, 0, 2'b11, 2'b00, 2, 1, 2);
    run_phase("R11", 1, 0, 31, 0, 0, 1, 0, 2'b11, 2'b10, 2, 0, 4);
    run_phase("R12", 1, 1, 31, 0, 0, 1, 1, 2'b01, 2'b10, 2, 1, 3);
    run_phase("R12", 0, 0, 31, 0, 0, 0, 0, 2'b11, 2'b10, 2, 1, 2);
    run_phase("R13", 1, 1, 31, 0, 0, 1, 0, 2'b11, 2'b10, 2, 1, 1);
    repeat (150) @(posedge clk);
    #1 en = 0;
    @(posedge clk); #1 en = 1;
    repeat (600) @(posedge clk);
    #1 en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13", "idle sdata_oe", sdata_oe, 1'b0);
    chk("R13", "idle fclk", fclk, fclk_inv);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired tag=%s actual=running expected=finished", tag);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule